// File: doc/BRIEF.md
# Minifloat Adder

This block adds two 8-bit floating-point words and returns their sum as a word of the same format. The format has one sign bit, three exponent bits and four fraction bits, with a hidden leading one on normal values. The datapath has two register stages. The first stage decodes both operands, orders them by magnitude, aligns the smaller one and adds or subtracts the significands. The second stage normalizes the raw sum, rounds it to nearest-even and packs it. It also resolves the special cases: NaN, infinity, overflow, underflow and zero sign.

A result is accepted on every cycle that `in_vld` is high. The result appears two cycles later with `out_vld` high. There is no stall or back-pressure, so a new pair may enter on every clock. Inputs with a zero exponent and a nonzero fraction (subnormals) are read as zero of the same sign. Results below the smallest normal magnitude (0.25) are flushed to zero.

Top module: `minifloat_adder`

## Requirements
- R1: A word holds the sign in bit 7, the exponent in bits 6:4 and the fraction in bits 3:0, with bias 3. A normal value is (-1)^s x 1.fff x 2^(e-3) for e in 1..6, so -0.75 is 8'hA8 and 1.0 is 8'h30.
- R2: `out_vld` is high exactly two clock cycles after each cycle in which `in_vld` is high, and low otherwise. Pairs may arrive on consecutive cycles.
- R3: The operand with the smaller magnitude has its significand shifted right by the exponent difference before the add (1.0 + 0.25 gives 8'h34).
- R4: When the significand sum reaches 2.0 or more, it is shifted right by one and the exponent rises by one (1.5 + 1.5 gives 8'h48).
- R5: After a subtraction, the difference is shifted left by its count of leading zeros, and the exponent drops by that count (1.5 - 1.25 gives 8'h10).
- R6: Rounding to four fraction bits is round-to-nearest, ties-to-even, using guard, round and sticky bits (8.0 + 0.25 gives 8'h60; 8.5 + 0.25 gives 8'h62).
- R7: A carry out of the rounding increment renormalizes once more (7.5 + 0.40625 gives 8'h60).
- R8: Exponent 7 with a nonzero fraction is NaN. Any NaN operand, or +inf plus -inf, gives the quiet NaN 8'h78.
- R9: Exponent 7 with fraction 0 is infinity, signed by bit 7. Infinity plus a finite value, or plus an infinity of the same sign, returns that infinity.
- R10: A finite sum whose exponent reaches 7 or more after rounding gives infinity with the sum's sign (8'h70 or 8'hF0).
- R11: A nonzero sum whose magnitude is below 0.25 gives zero with the sum's sign. Inputs with exponent 0 count as zero.
- R12: An exact cancellation of nonzero operands gives +0 (8'h00). Two zeros give -0 only when both are -0.
- R13: During and after reset, before any input, `out_vld` and `out_sum` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low reset, synchronous release |
| in_vld | input | 1 | Operand pair valid this cycle |
| in_a | input | 8 | First operand word |
| in_b | input | 8 | Second operand word |
| out_vld | output | 1 | Sum valid this cycle |
| out_sum | output | 8 | Encoded sum |

## Verification
The assertions assume that `in_a` and `in_b` are known whenever `in_vld` is high. They also assume that `in_vld` never has an X value once reset is released. The bench drives the inputs only on falling edges and keeps `in_vld` low for the whole of reset, so the two-cycle checks never look back into reset. The stimulus sweeps every one of the 65,536 operand pairs on consecutive cycles, which covers subnormal, NaN and infinity encodings. Directed pairs with idle gaps between them come first, and each is checked against hand-derived words.

// File: rtl/minifloat_pkg.sv
package minifloat_pkg;

   // Operand or result class carried between the stages.
   typedef enum logic [1:0] {
      MF_ZERO = 2'd0,
      MF_FIN  = 2'd1,
      MF_INF  = 2'd2,
      MF_NAN  = 2'd3
   } mf_kind_e;

   // Extra bits below the significand: guard, round, sticky.
   localparam int GRS_W = 3;

endpackage

// File: rtl/mf_unpack.sv
module mf_unpack
   import minifloat_pkg::*;
#(
   parameter int EXP_W  = 3,
   parameter int FRAC_W = 4
) (
   input  logic [EXP_W+FRAC_W:0] word,
   output logic                  sign,
   output logic [EXP_W-1:0]      expo,
   output logic [FRAC_W:0]       sig,
   output mf_kind_e              kind
);

   localparam logic [EXP_W-1:0] EXP_TOP = '1;

   logic [FRAC_W-1:0] frac;

   always_comb begin
      sign = word[EXP_W+FRAC_W];
      expo = word[EXP_W+FRAC_W-1:FRAC_W];
      frac = word[FRAC_W-1:0];
      if (expo == '0) begin
         // subnormals are read as zero
         kind = MF_ZERO;
         sig  = '0;
      end else if (expo == EXP_TOP) begin
         kind = (frac == '0) ? MF_INF : MF_NAN;
         sig  = '0;
      end else begin
         kind = MF_FIN;
         sig  = {1'b1, frac};
      end
   end

endmodule

// File: rtl/mf_align_add.sv
module mf_align_add
   import minifloat_pkg::*;
#(
   parameter int EXP_W  = 3,
   parameter int FRAC_W = 4
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    in_vld,
   input  logic                    a_sign,
   input  logic [EXP_W-1:0]        a_exp,
   input  logic [FRAC_W:0]         a_sig,
   input  mf_kind_e                a_kind,
   input  logic                    b_sign,
   input  logic [EXP_W-1:0]        b_exp,
   input  logic [FRAC_W:0]         b_sig,
   input  mf_kind_e                b_kind,
   output logic                    s1_vld,
   output mf_kind_e                s1_kind,
   output logic                    s1_sign,
   output logic [EXP_W-1:0]        s1_exp,
   output logic [FRAC_W+GRS_W+1:0] s1_sum
);

   localparam int SW = FRAC_W + 1;
   localparam int AW = SW + GRS_W;

   logic             a_big;
   logic             big_sign;
   logic [EXP_W-1:0] big_exp, small_exp, diff;
   logic [AW-1:0]    big_ext, small_ext, shifted, aligned, low_mask;
   logic             sticky, op_sub;
   logic [AW:0]      sum_w;
   mf_kind_e         kind_w;
   logic             sign_w;

   // Order by magnitude so that a subtraction never wraps.
   assign a_big     = {a_exp, a_sig} >= {b_exp, b_sig};
   assign big_exp   = a_big ? a_exp : b_exp;
   assign small_exp = a_big ? b_exp : a_exp;
   assign big_sign  = a_big ? a_sign : b_sign;
   assign big_ext   = {(a_big ? a_sig : b_sig), {GRS_W{1'b0}}};
   assign small_ext = {(a_big ? b_sig : a_sig), {GRS_W{1'b0}}};
   assign diff      = big_exp - small_exp;

   // Mask of the bit positions that the alignment shift drops.
   for (genvar i = 0; i < AW; i++) begin : g_mask
      assign low_mask[i] = int'(diff) > i;
   end

   assign sticky  = |(small_ext & low_mask);
   assign shifted = small_ext >> diff;
   assign aligned = {shifted[AW-1:1], shifted[0] | sticky};
   assign op_sub  = a_sign ^ b_sign;
   assign sum_w   = op_sub ? ({1'b0, big_ext} - {1'b0, aligned})
                           : ({1'b0, big_ext} + {1'b0, aligned});

   always_comb begin
      kind_w = MF_FIN;
      sign_w = big_sign;
      if (a_kind == MF_NAN || b_kind == MF_NAN ||
          (a_kind == MF_INF && b_kind == MF_INF && op_sub)) begin
         kind_w = MF_NAN;
      end else if (a_kind == MF_INF) begin
         kind_w = MF_INF;
         sign_w = a_sign;
      end else if (b_kind == MF_INF) begin
         kind_w = MF_INF;
         sign_w = b_sign;
      end else if (sum_w == '0 && op_sub) begin
         sign_w = 1'b0;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         s1_vld  <= 1'b0;
         s1_kind <= MF_ZERO;
         s1_sign <= 1'b0;
         s1_exp  <= '0;
         s1_sum  <= '0;
      end else begin
         s1_vld <= in_vld;
         if (in_vld) begin
            s1_kind <= kind_w;
            s1_sign <= sign_w;
            s1_exp  <= big_exp;
            s1_sum  <= sum_w;
         end
      end
   end

   // R3
   no_borrow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_vld && a_kind == MF_FIN && b_kind == MF_FIN && op_sub) |-> !sum_w[AW]);

endmodule

// File: rtl/mf_norm_round.sv
module mf_norm_round
   import minifloat_pkg::*;
#(
   parameter int EXP_W  = 3,
   parameter int FRAC_W = 4
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    s1_vld,
   input  mf_kind_e                s1_kind,
   input  logic                    s1_sign,
   input  logic [EXP_W-1:0]        s1_exp,
   input  logic [FRAC_W+GRS_W+1:0] s1_sum,
   output logic                    out_vld,
   output logic [EXP_W+FRAC_W:0]   out_word
);

   localparam int SW    = FRAC_W + 1;
   localparam int AW    = SW + GRS_W;
   localparam int W     = 1 + EXP_W + FRAC_W;
   localparam int LZW   = $clog2(AW + 1);
   localparam int EW    = ((EXP_W > LZW) ? EXP_W : LZW) + 2;
   localparam int EMAX  = (1 << EXP_W) - 1;
   localparam logic [W-1:0] QNAN = {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};

   logic [LZW-1:0]       lz;
   logic [AW-1:0]        norm;
   logic signed [EW-1:0] e_n, e_f;
   logic [SW-1:0]        sig_pre, sig_f;
   logic [SW:0]          sig_r;
   logic                 g_bit, rs_bit, rnd_up;
   logic [W-1:0]         res;

   // Leading-zero count of the sum below its carry bit.
   always_comb begin
      lz = LZW'(AW);
      for (int i = 0; i < AW; i++) begin
         if (s1_sum[i]) lz = LZW'(AW - 1 - i);
      end
   end

   always_comb begin
      if (s1_sum[AW]) begin
         norm = {s1_sum[AW:2], |s1_sum[1:0]};
         e_n  = $signed(EW'({1'b0, s1_exp})) + $signed(EW'(1));
      end else begin
         norm = s1_sum[AW-1:0] << lz;
         e_n  = $signed(EW'({1'b0, s1_exp})) - $signed(EW'({1'b0, lz}));
      end
   end

   assign sig_pre = norm[AW-1:GRS_W];
   assign g_bit   = norm[GRS_W-1];
   assign rs_bit  = |norm[GRS_W-2:0];
   assign rnd_up  = g_bit & (rs_bit | sig_pre[0]);
   assign sig_r   = {1'b0, sig_pre} + (SW+1)'(rnd_up);

   always_comb begin
      if (sig_r[SW]) begin
         sig_f = sig_r[SW:1];
         e_f   = e_n + $signed(EW'(1));
      end else begin
         sig_f = sig_r[SW-1:0];
         e_f   = e_n;
      end
   end

   always_comb begin
      if (s1_kind == MF_NAN) begin
         res = QNAN;
      end else if (s1_kind == MF_INF) begin
         res = {s1_sign, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
      end else if (s1_sum == '0 || e_n < $signed(EW'(1))) begin
         res = {s1_sign, {(W-1){1'b0}}};
      end else if (e_f >= $signed(EW'(EMAX))) begin
         res = {s1_sign, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
      end else begin
         res = {s1_sign, e_f[EXP_W-1:0], sig_f[FRAC_W-1:0]};
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_vld  <= 1'b0;
         out_word <= '0;
      end else begin
         out_vld <= s1_vld;
         if (s1_vld) out_word <= res;
      end
   end

   // R5
   norm_lead_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (s1_vld && s1_kind == MF_FIN && s1_sum != '0) |-> norm[AW-1]);

   // R11
   zero_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_vld && out_word[W-2:FRAC_W] == '0) |-> (out_word[FRAC_W-1:0] == '0));

endmodule

// File: rtl/minifloat_adder.sv
module minifloat_adder
   import minifloat_pkg::*;
#(
   parameter int EXP_W  = 3,
   parameter int FRAC_W = 4
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  in_vld,
   input  logic [EXP_W+FRAC_W:0] in_a,
   input  logic [EXP_W+FRAC_W:0] in_b,
   output logic                  out_vld,
   output logic [EXP_W+FRAC_W:0] out_sum
);

   localparam int W  = 1 + EXP_W + FRAC_W;
   localparam int SW = FRAC_W + 1;
   localparam int AW = SW + GRS_W;
   localparam logic [W-1:0] QNAN = {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};

   if (EXP_W < 2) begin : g_bad_exp
      $error("minifloat_adder: EXP_W must be at least 2");
   end
   if (FRAC_W < 2) begin : g_bad_frac
      $error("minifloat_adder: FRAC_W must be at least 2");
   end

   logic [W-1:0]       ops    [2];
   logic               op_sgn [2];
   logic [EXP_W-1:0]   op_exp [2];
   logic [SW-1:0]      op_sig [2];
   mf_kind_e           op_knd [2];

   assign ops[0] = in_a;
   assign ops[1] = in_b;

   for (genvar k = 0; k < 2; k++) begin : g_dec
      mf_unpack #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_dec (
         .word (ops[k]),
         .sign (op_sgn[k]),
         .expo (op_exp[k]),
         .sig  (op_sig[k]),
         .kind (op_knd[k])
      );
   end

   logic             s1_vld;
   mf_kind_e         s1_kind;
   logic             s1_sign;
   logic [EXP_W-1:0] s1_exp;
   logic [AW:0]      s1_sum;

   mf_align_add #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_stage1 (
      .clk     (clk),
      .rst_n   (rst_n),
      .in_vld  (in_vld),
      .a_sign  (op_sgn[0]),
      .a_exp   (op_exp[0]),
      .a_sig   (op_sig[0]),
      .a_kind  (op_knd[0]),
      .b_sign  (op_sgn[1]),
      .b_exp   (op_exp[1]),
      .b_sig   (op_sig[1]),
      .b_kind  (op_knd[1]),
      .s1_vld  (s1_vld),
      .s1_kind (s1_kind),
      .s1_sign (s1_sign),
      .s1_exp  (s1_exp),
      .s1_sum  (s1_sum)
   );

   mf_norm_round #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_stage2 (
      .clk      (clk),
      .rst_n    (rst_n),
      .s1_vld   (s1_vld),
      .s1_kind  (s1_kind),
      .s1_sign  (s1_sign),
      .s1_exp   (s1_exp),
      .s1_sum   (s1_sum),
      .out_vld  (out_vld),
      .out_word (out_sum)
   );

   // R2
   latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_vld |-> ##2 out_vld);

   // R2
   idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !in_vld |-> ##2 !out_vld);

   // R8
   nan_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_vld && in_a[W-2:FRAC_W] == '1 && in_a[FRAC_W-1:0] != '0)
      |-> ##2 (out_sum == QNAN));

   // R9
   inf_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_vld && in_a[W-2:0] == {{EXP_W{1'b1}}, {FRAC_W{1'b0}}} && in_b[W-2:FRAC_W] != '1)
      |-> ##2 (out_sum == $past(in_a, 2)));

   // R12
   cancel_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_vld && in_a == {~in_b[W-1], in_b[W-2:0]} && in_a[W-2:FRAC_W] != '0
       && in_a[W-2:FRAC_W] != '1)
      |-> ##2 (out_sum == '0));

endmodule

// File: tb/minifloat_adder_bench.sv
module minifloat_adder_bench;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       in_vld = 1'b0;
   logic [7:0] in_a = 8'h00;
   logic [7:0] in_b = 8'h00;
   logic       out_vld;
   logic [7:0] out_sum;

   int checks = 0;
   int errors = 0;
   int cyc = 0;

   typedef struct {
      logic [7:0] a;
      logic [7:0] b;
      logic [7:0] want;
      int         at;
      string      tag;
   } item_t;

   item_t sb_q[$];

   always #2 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   minifloat_adder u_minifloat_adder (
      .clk     (clk),
      .rst_n   (rst_n),
      .in_vld  (in_vld),
      .in_a    (in_a),
      .in_b    (in_b),
      .out_vld (out_vld),
      .out_sum (out_sum)
   );

   // Exact model: magnitudes in units of 2^-6, then round to nearest even.
   function automatic logic [7:0] ref_add(logic [7:0] a, logic [7:0] b);
      logic an, bn, ai, bi, sg;
      int ma, mb, s, m, p, sh, sig, rem, half, e;
      an = (a[6:4] == 3'd7) && (a[3:0] != 4'd0);
      bn = (b[6:4] == 3'd7) && (b[3:0] != 4'd0);
      ai = (a[6:4] == 3'd7) && (a[3:0] == 4'd0);
      bi = (b[6:4] == 3'd7) && (b[3:0] == 4'd0);
      if (an || bn) return 8'h78;
      if (ai && bi) return (a[7] == b[7]) ? a : 8'h78;
      if (ai) return a;
      if (bi) return b;
      ma = (a[6:4] == 3'd0) ? 0 : ((16 + int'(a[3:0])) << (int'(a[6:4]) - 1));
      mb = (b[6:4] == 3'd0) ? 0 : ((16 + int'(b[3:0])) << (int'(b[6:4]) - 1));
      s = (a[7] ? -ma : ma) + (b[7] ? -mb : mb);
      if (s == 0) return {(ma == 0 && mb == 0 && a[7] && b[7]), 7'd0};
      sg = (s < 0);
      m = sg ? -s : s;
      if (m < 16) return {sg, 7'd0};
      p = 0;
      for (int i = 0; i < 16; i++) if ((m >> i) != 0) p = i;
      sh = p - 4;
      sig = m >> sh;
      rem = m - (sig << sh);
      half = (sh > 0) ? (1 << (sh - 1)) : 0;
      if (sh > 0 && (rem > half || (rem == half && (sig % 2) == 1))) sig = sig + 1;
      e = sh + 1;
      if (sig == 32) begin
         sig = 16;
         e = e + 1;
      end
      if (e >= 7) return {sg, 7'h70};
      return {sg, 3'(e), 4'(sig)};
   endfunction

   function automatic string tag_of(logic [7:0] a, logic [7:0] b, logic [7:0] r);
      if ((a[6:4] == 3'd7 && a[3:0] != 0) || (b[6:4] == 3'd7 && b[3:0] != 0) || r == 8'h78)
         return "R8";
      if (a[6:4] == 3'd7 || b[6:4] == 3'd7) return "R9";
      if (r[6:4] == 3'd7) return "R10";
      if (r[6:0] == 7'd0) return "R12";
      return "R6";
   endfunction

   task automatic send(logic [7:0] a, logic [7:0] b, logic [7:0] want, string tag);
      item_t it;
      @(negedge clk);
      in_vld = 1'b1;
      in_a = a;
      in_b = b;
      it.a = a;
      it.b = b;
      it.want = want;
      it.at = cyc;
      it.tag = tag;
      sb_q.push_back(it);
   endtask

   task automatic idle(int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         in_vld = 1'b0;
      end
   endtask

   task automatic report(logic ok, string tag, string what, int got, int want);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: got %0h expected %0h", tag, what, got, want);
      end
   endtask

   // Monitor: pop the oldest expectation for every output strobe.
   always @(negedge clk) begin
      if (rst_n && out_vld) begin
         if (sb_q.size() == 0) begin
            report(1'b0, "R2", "unexpected out_vld", 1, 0);
         end else begin
            item_t it;
            it = sb_q.pop_front();
            report(cyc - it.at == 2, "R2", "latency", cyc - it.at, 2);
            report(out_sum == it.want, it.tag, $sformatf("sum of %h+%h", it.a, it.b),
                   int'(out_sum), int'(it.want));
         end
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      report(1'b0, "R2", "watchdog expired", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (4) @(negedge clk);
      // R13 reset state, inside and after reset
      report(out_vld == 1'b0 && out_sum == 8'h00, "R13", "in reset", int'(out_sum), 0);
      rst_n = 1'b1;
      idle(3);
      report(out_vld == 1'b0 && out_sum == 8'h00, "R13", "after reset", int'(out_sum), 0);

      send(8'hA0, 8'h90, 8'hA8, "R1");   // -0.5 + -0.25 = -0.75
      send(8'h28, 8'h00, 8'h28, "R1");
      idle(2);
      send(8'h30, 8'h10, 8'h34, "R3");   // 1.0 + 0.25
      send(8'h5E, 8'h1A, 8'h60, "R7");   // 7.5 + 0.40625 rounds up to 8.0
      send(8'h38, 8'h38, 8'h48, "R4");   // 1.5 + 1.5
      send(8'h5F, 8'h5F, 8'h6F, "R4");
      idle(1);
      send(8'h38, 8'hB4, 8'h10, "R5");   // 1.5 - 1.25
      send(8'h4F, 8'hC8, 8'h2C, "R5");   // 3.875 - 3.0
      send(8'h60, 8'h10, 8'h60, "R6");   // tie to even, stays
      send(8'h61, 8'h10, 8'h62, "R6");   // tie to even, rounds up
      send(8'h60, 8'h9A, 8'h5E, "R6");   // subtraction rounds down
      send(8'h79, 8'h30, 8'h78, "R8");
      send(8'h30, 8'hFF, 8'h78, "R8");
      send(8'h70, 8'hF0, 8'h78, "R8");
      idle(3);
      send(8'h70, 8'hB0, 8'h70, "R9");
      send(8'hF0, 8'h6F, 8'hF0, "R9");
      send(8'hF0, 8'hF0, 8'hF0, "R9");
      send(8'h68, 8'h68, 8'h70, "R10");
      send(8'hE8, 8'hE8, 8'hF0, "R10");
      send(8'h6F, 8'h10, 8'h70, "R10");
      send(8'h14, 8'h90, 8'h00, "R11");
      send(8'h94, 8'h10, 8'h80, "R11");
      send(8'h05, 8'h30, 8'h30, "R11");
      send(8'h30, 8'hB0, 8'h00, "R12");
      send(8'h80, 8'h80, 8'h80, "R12");
      send(8'h80, 8'h00, 8'h00, "R12");
      idle(2);

      // Every operand pair, back to back.
      for (int i = 0; i < 256; i++) begin
         for (int j = 0; j < 256; j++) begin
            logic [7:0] r;
            r = ref_add(8'(i), 8'(j));
            send(8'(i), 8'(j), r, tag_of(8'(i), 8'(j), r));
         end
      end
      idle(6);
      report(sb_q.size() == 0, "R2", "results missing", sb_q.size(), 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule